// File: doc/BRIEF.md
# Adapter Interrupt Suppression Controller

This block decides, for each of eight interruption subclasses, whether a suppressible adapter interrupt request goes on to the I/O interrupt queue or is dropped. Each subclass keeps two state bits. The first is a "one-shot" bit that selects single-interruption mode. The second is a "muted" bit that selects no-interruptions mode. Software writes these bits through a mode command that carries a subclass and a mode code. Adapter hardware raises requests that carry a subclass and a suppressible flag.

A request that is not dropped leaves the block as a one-cycle inject strobe. The strobe carries an interrupt word built from the subclass. The subchannel identifier, subchannel number and parameter fields are all zero. In one-shot mode, the first suppressible request that goes through mutes its subclass. Every later suppressible request for that subclass is then dropped, until software sends a new mode command. A dropped request raises a one-cycle suppressed pulse. An unknown mode code raises a one-cycle error pulse. The queue that receives the strobe is outside this block.

Top module: `irqsup_ctrl`

## Requirements
- R1: After reset, every subclass is in all-interrupts mode: both state bits are clear and every output is low. A suppressible request to any subclass is therefore forwarded.
- R2: Mode code 0 (all-interrupts) clears both the one-shot bit and the muted bit of the addressed subclass.
- R3: Mode code 1 (single-interruption) sets the one-shot bit and clears the muted bit of the addressed subclass.
- R4: Any other mode code raises `mode_err` for one cycle, in the cycle after the command, and leaves every state bit unchanged.
- R5: A suppressible request to a muted subclass is dropped. `supp_pulse` rises in the cycle after the request and `inj_valid` stays low.
- R6: A request that is not dropped raises `inj_valid` in the cycle after the request. `inj_word` has bit 31 set, carries the subclass in bits 29:27, and has all other bits zero. `inj_sch_id`, `inj_sch_nr` and `inj_parm` are zero.
- R7: When a suppressible request is forwarded for a subclass whose one-shot bit is set, that subclass becomes muted.
- R8: A request whose suppressible flag is low is always forwarded and changes no state bit.
- R9: When a mode command and a request arrive in the same cycle, the mode command takes effect first and the request is judged against the new state.
- R10: `inj_valid`, `supp_pulse` and `mode_err` are single-cycle pulses. `inj_valid` and `supp_pulse` are never high together.
- R11: The state of each subclass is independent: a command or request for one subclass never changes the outcome for another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_valid | input | 1 | Mode command strobe |
| mode_class | input | 3 | Subclass addressed by the mode command |
| mode_code | input | 16 | Mode code: 0 selects all-interrupts, 1 selects single-interruption |
| req_valid | input | 1 | Adapter interrupt request strobe |
| req_class | input | 3 | Subclass of the request |
| req_suppressible | input | 1 | Request may be suppressed |
| inj_valid | output | 1 | Forwarded I/O inject strobe |
| inj_word | output | 32 | Formed interrupt word |
| inj_sch_id | output | 16 | Subchannel identifier of the inject (always zero) |
| inj_sch_nr | output | 16 | Subchannel number of the inject (always zero) |
| inj_parm | output | 32 | Interrupt parameter of the inject (always zero) |
| supp_pulse | output | 1 | A request was dropped |
| mode_err | output | 1 | The mode command carried an unknown code |

## Verification
Every result is registered once, so `inj_valid`, `inj_word`, `supp_pulse` and `mode_err` all answer a stimulus exactly one clock edge later. A state change made by a command or a request shows up in the result of the next request.

The bench drives one stimulus just after an edge and samples one nanosecond after the following edge. It then returns the inputs to idle, so each sample belongs to exactly one stimulus. The state bits are never read directly. They are observed through later requests, which a per-subclass model in the bench predicts.

// File: rtl/irqsup_pkg.sv
package irqsup_pkg;

  localparam int MODE_W = 16;

  localparam logic [MODE_W-1:0] MODE_ALL    = 16'd0;
  localparam logic [MODE_W-1:0] MODE_SINGLE = 16'd1;

  typedef struct packed {
    logic apply;   // known code, update the addressed subclass
    logic single;  // 1: single-interruption, 0: all-interrupts
    logic bad;     // unknown code
  } mode_cmd_t;

  function automatic mode_cmd_t decode_mode(input logic valid,
                                            input logic [MODE_W-1:0] code);
    mode_cmd_t c;
    c.apply  = valid && (code == MODE_ALL || code == MODE_SINGLE);
    c.single = (code == MODE_SINGLE);
    c.bad    = valid && !(code == MODE_ALL || code == MODE_SINGLE);
    return c;
  endfunction

endpackage

// File: rtl/irqsup_mode_dec.sv
module irqsup_mode_dec
  import irqsup_pkg::*;
#(
  parameter int NUM_CLASS = 8,
  localparam int CLASS_W  = $clog2(NUM_CLASS)
) (
  input  logic                 mode_valid,
  input  logic [CLASS_W-1:0]   mode_class,
  input  logic [MODE_W-1:0]    mode_code,
  output logic [NUM_CLASS-1:0] hit_vec,
  output logic                 single_sel,
  output logic                 bad_code
);
  mode_cmd_t cmd;

  always_comb cmd = decode_mode(mode_valid, mode_code);

  assign single_sel = cmd.single;
  assign bad_code   = cmd.bad;

  for (genvar i = 0; i < NUM_CLASS; i++) begin : g_hit
    assign hit_vec[i] = cmd.apply && (mode_class == CLASS_W'(i));
  end
endmodule

// File: rtl/irqsup_class_slot.sv
module irqsup_class_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_hit,
  input  logic mode_single,
  input  logic sreq_hit,
  output logic oneshot_q,
  output logic muted_q,
  output logic drop_o,
  output logic arm_o
);
  logic oneshot_mid;
  logic muted_mid;

  // the mode command is applied before the request is judged
  always_comb begin
    oneshot_mid = mode_hit ? mode_single : oneshot_q;
    muted_mid   = mode_hit ? 1'b0        : muted_q;
    drop_o      = sreq_hit && muted_mid;
    arm_o       = sreq_hit && !muted_mid && oneshot_mid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oneshot_q <= 1'b0;
      muted_q   <= 1'b0;
    end else begin
      oneshot_q <= oneshot_mid;
      muted_q   <= muted_mid | arm_o;
    end
  end
endmodule

// File: rtl/irqsup_word_fmt.sv
module irqsup_word_fmt #(
  parameter int CLASS_W   = 3,
  parameter int WORD_W    = 32,
  parameter int CLS_SHIFT = 27,
  parameter int AI_BIT    = 31
) (
  input  logic [CLASS_W-1:0] cls,
  output logic [WORD_W-1:0]  word
);
  function automatic logic [WORD_W-1:0] form_word(input logic [CLASS_W-1:0] c);
    logic [WORD_W-1:0] w;
    w         = WORD_W'(c) << CLS_SHIFT;
    w[AI_BIT] = 1'b1;
    return w;
  endfunction

  assign word = form_word(cls);
endmodule

// File: rtl/irqsup_ctrl.sv
module irqsup_ctrl
  import irqsup_pkg::*;
#(
  parameter int NUM_CLASS = 8,
  parameter int WORD_W    = 32,
  parameter int SCH_W     = 16,
  parameter int PARM_W    = 32,
  parameter int CLS_SHIFT = 27,
  parameter int AI_BIT    = 31,
  localparam int CLASS_W  = $clog2(NUM_CLASS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_valid,
  input  logic [CLASS_W-1:0] mode_class,
  input  logic [MODE_W-1:0]  mode_code,
  input  logic               req_valid,
  input  logic [CLASS_W-1:0] req_class,
  input  logic               req_suppressible,
  output logic               inj_valid,
  output logic [WORD_W-1:0]  inj_word,
  output logic [SCH_W-1:0]   inj_sch_id,
  output logic [SCH_W-1:0]   inj_sch_nr,
  output logic [PARM_W-1:0]  inj_parm,
  output logic               supp_pulse,
  output logic               mode_err
);
  logic [NUM_CLASS-1:0] mode_hit_vec;
  logic [NUM_CLASS-1:0] sreq_hit_vec;
  logic [NUM_CLASS-1:0] oneshot_vec;
  logic [NUM_CLASS-1:0] muted_vec;
  logic [NUM_CLASS-1:0] drop_vec;
  logic [NUM_CLASS-1:0] arm_vec;
  logic                 single_sel;
  logic                 bad_code;
  logic                 drop_any;
  logic                 fwd_now;
  logic [WORD_W-1:0]    word_now;

  irqsup_mode_dec #(.NUM_CLASS(NUM_CLASS)) u_dec (
    .mode_valid (mode_valid),
    .mode_class (mode_class),
    .mode_code  (mode_code),
    .hit_vec    (mode_hit_vec),
    .single_sel (single_sel),
    .bad_code   (bad_code)
  );

  for (genvar i = 0; i < NUM_CLASS; i++) begin : g_slot
    assign sreq_hit_vec[i] = req_valid && req_suppressible && (req_class == CLASS_W'(i));

    irqsup_class_slot u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_hit    (mode_hit_vec[i]),
      .mode_single (single_sel),
      .sreq_hit    (sreq_hit_vec[i]),
      .oneshot_q   (oneshot_vec[i]),
      .muted_q     (muted_vec[i]),
      .drop_o      (drop_vec[i]),
      .arm_o       (arm_vec[i])
    );
  end

  irqsup_word_fmt #(
    .CLASS_W(CLASS_W), .WORD_W(WORD_W), .CLS_SHIFT(CLS_SHIFT), .AI_BIT(AI_BIT)
  ) u_fmt (
    .cls  (req_class),
    .word (word_now)
  );

  assign drop_any = |drop_vec;
  assign fwd_now  = req_valid && !drop_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inj_valid  <= 1'b0;
      inj_word   <= '0;
      supp_pulse <= 1'b0;
      mode_err   <= 1'b0;
    end else begin
      inj_valid  <= fwd_now;
      inj_word   <= fwd_now ? word_now : '0;
      supp_pulse <= drop_any;
      mode_err   <= bad_code;
    end
  end

  assign inj_sch_id = '0;
  assign inj_sch_nr = '0;
  assign inj_parm   = '0;
endmodule

// File: rtl/irqsup_ctrl_chk.sv
module irqsup_ctrl_chk #(
  parameter int NUM_CLASS = 8,
  parameter int WORD_W    = 32,
  parameter int SCH_W     = 16,
  parameter int AI_BIT    = 31,
  localparam int CLASS_W  = $clog2(NUM_CLASS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 mode_valid,
  input logic [CLASS_W-1:0]   mode_class,
  input logic [15:0]          mode_code,
  input logic                 req_valid,
  input logic [CLASS_W-1:0]   req_class,
  input logic                 req_suppressible,
  input logic                 inj_valid,
  input logic [WORD_W-1:0]    inj_word,
  input logic [SCH_W-1:0]     inj_sch_id,
  input logic                 supp_pulse,
  input logic                 mode_err,
  input logic [NUM_CLASS-1:0] oneshot_vec,
  input logic [NUM_CLASS-1:0] muted_vec
);
  p_mode_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid && mode_code == 16'd0
    |=> !oneshot_vec[$past(mode_class)] && !muted_vec[$past(mode_class)]);

  p_bad_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid && mode_code != 16'd0 && mode_code != 16'd1 |=> mode_err);

  p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_suppressible && !mode_valid && muted_vec[req_class]
    |=> supp_pulse && !inj_valid);

  p_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inj_valid |-> inj_word[AI_BIT] && inj_sch_id == '0);

  p_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_suppressible && !mode_valid
      && oneshot_vec[req_class] && !muted_vec[req_class]
    |=> muted_vec[$past(req_class)]);

  p_plain_fwd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_suppressible |=> inj_valid && !supp_pulse);

  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(inj_valid && supp_pulse));
endmodule

bind irqsup_ctrl irqsup_ctrl_chk #(
  .NUM_CLASS(NUM_CLASS), .WORD_W(WORD_W), .SCH_W(SCH_W), .AI_BIT(AI_BIT)
) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .mode_valid       (mode_valid),
  .mode_class       (mode_class),
  .mode_code        (mode_code),
  .req_valid        (req_valid),
  .req_class        (req_class),
  .req_suppressible (req_suppressible),
  .inj_valid        (inj_valid),
  .inj_word         (inj_word),
  .inj_sch_id       (inj_sch_id),
  .supp_pulse       (supp_pulse),
  .mode_err         (mode_err),
  .oneshot_vec      (oneshot_vec),
  .muted_vec        (muted_vec)
);

// File: tb/irqsup_ctrl_test.sv
`timescale 1ns/1ps
module irqsup_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_valid = 1'b0;
  logic [2:0]  mode_class = '0;
  logic [15:0] mode_code = '0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_class = '0;
  logic        req_suppressible = 1'b0;
  logic        inj_valid;
  logic [31:0] inj_word;
  logic [15:0] inj_sch_id;
  logic [15:0] inj_sch_nr;
  logic [31:0] inj_parm;
  logic        supp_pulse;
  logic        mode_err;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;
  bit m_one[8];
  bit m_mute[8];

  always #2.5 clk = ~clk;

  irqsup_ctrl uut (
    .clk(clk), .rst_n(rst_n), .mode_valid(mode_valid), .mode_class(mode_class),
    .mode_code(mode_code), .req_valid(req_valid), .req_class(req_class),
    .req_suppressible(req_suppressible), .inj_valid(inj_valid), .inj_word(inj_word),
    .inj_sch_id(inj_sch_id), .inj_sch_nr(inj_sch_nr), .inj_parm(inj_parm),
    .supp_pulse(supp_pulse), .mode_err(mode_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one stimulus cycle; results sampled 1 ns after the next edge
  task automatic step(input bit mv, input int mc, input int code,
                      input bit rv, input int rc, input bit rs, input string req);
    bit e_err, e_inj, e_sup;
    logic [31:0] e_word;
    e_err = 0; e_inj = 0; e_sup = 0; e_word = 0;
    mode_valid = mv; mode_class = 3'(mc); mode_code = 16'(code);
    req_valid = rv; req_class = 3'(rc); req_suppressible = rs;
    if (mv) begin
      if (code == 0) begin m_one[mc] = 0; m_mute[mc] = 0; end
      else if (code == 1) begin m_one[mc] = 1; m_mute[mc] = 0; end
      else e_err = 1;
    end
    if (rv) begin
      if (rs && m_mute[rc]) e_sup = 1;
      else begin
        e_inj  = 1;
        e_word = 32'h8000_0000 + rc * 32'd134217728;
        if (rs && m_one[rc]) m_mute[rc] = 1;
      end
    end
    @(posedge clk); #1;
    mode_valid = 0; req_valid = 0;
    chk({req, " inj_valid"}, 32'(inj_valid), 32'(e_inj));
    chk({req, " supp_pulse"}, 32'(supp_pulse), 32'(e_sup));
    chk({req, " mode_err"}, 32'(mode_err), 32'(e_err));
    if (e_inj) chk({req, " R6 inj_word"}, inj_word, e_word);
    chk({req, " R6 zero fields"}, {inj_sch_id, inj_sch_nr} | inj_parm, 32'd0);
  endtask

  task automatic idle(input string req);
    step(0, 0, 0, 0, 0, 0, req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset inj_valid", 32'(inj_valid), 0);
    chk("R1 reset supp_pulse", 32'(supp_pulse), 0);
    chk("R1 reset mode_err", 32'(mode_err), 0);
    rst_n = 1'b1;
    for (int c = 0; c < 8; c++) step(0, 0, 0, 1, c, 1, "R1 fresh suppressible");

    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 4; k++) begin
        int code;
        code = (k == 3) ? 16'hFFFF : k;
        step(1, c, 0, 0, 0, 0, "R2 clear");
        step(1, c, 1, 0, 0, 0, "R3 single");
        step(1, c, code, 0, 0, 0, (k > 1) ? "R4 bad code" : "R2 R3 mode");
        idle("R10 pulse end");
        step(0, 0, 0, 1, c, 1, "R7 first suppressible");
        step(0, 0, 0, 1, c, 1, "R5 R7 second suppressible");
        step(0, 0, 0, 1, c, 0, "R8 plain");
        step(0, 0, 0, 1, c, 1, "R5 R8 after plain");
        idle("R10 pulse end");
        step(0, 0, 0, 1, (c + 1) % 8, 1, "R11 neighbour");
        step(1, c, k, 1, c, 1, "R9 mode then req");
        step(0, 0, 0, 1, c, 1, "R9 follow-up");
        step(1, c, 0, 1, c, 1, "R9 R2 clear with req");
        step(0, 0, 0, 1, c, 1, "R2 after clear");
      end
    end
    step(1, 3, 1, 0, 0, 0, "R3 arm");
    step(0, 0, 0, 1, 3, 1, "R7 arm");
    rst_n = 1'b0;
    step(0, 0, 0, 0, 0, 0, "R1 in reset");
    rst_n = 1'b1;
    for (int c = 0; c < 8; c++) begin m_one[c] = 0; m_mute[c] = 0; end
    step(0, 0, 0, 1, 3, 1, "R1 reset clears");
    step(0, 0, 0, 1, 3, 1, "R1 reset clears one-shot");
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule